// File: doc/BRIEF.md
# Sensor Bus Node Interface

This block is the bus-side driver of one sensor or actuator node on a two-wire, single-master sensor bus. A master-driven clock line and a shared bidirectional data line connect the nodes. The node runs from its own local clock. A rising edge on the bus clock line aligns it to the start of a transmission. After that it times every half-bit with its own counters and decodes a Manchester-coded command frame from the data line. Every node hears every frame. A node responds only when the frame's address field equals its own address.

On a match the node hands the 4-bit command to the local sensor or actuator logic as a single-cycle strobe. Some command codes are read requests. For those, the node captures an 8-bit value from the local logic. After a fixed gap it sends that value back to the master on the same data line as a Manchester-coded reply frame. The node enables its line driver only while that reply is on the wire. Received frames get no error checking beyond a check of the framing bits. A frame with bad framing bits is dropped without any effect.

Top module: `sbus_node`

## Requirements
- R1: While `rst_i` is high, and on the first cycle after it falls, `bus_oe_o` and `cmd_valid_o` are low. A reset in the middle of a reply releases the data line.
- R2: A command frame has 11 bits, sent MSB first: a start bit of value 1, a 5-bit address, a 4-bit command and an end-of-frame bit of value 0. Each bit is one bit period long. A logic 1 is high for the first half and low for the second half; a logic 0 is the opposite.
- R3: `cmd_valid_o` pulses only for a well-formed frame whose address field equals `node_addr_i`. `cmd_o` then carries that frame's command field. A frame addressed to any other node leaves both outputs and the data line untouched.
- R4: A frame whose start bit is not 1, or whose end-of-frame bit is not 0, is discarded. It produces no strobe and no reply.
- R5: A matched command code c is a read request when bit c of `READ_MASK` is set (by default codes 4 to 7). Only read requests start a reply. Every other matched code only pulses `cmd_valid_o`.
- R6: A reply frame has 10 bits, sent MSB first with the same Manchester polarity as R2: a start bit of 1, the 8 bits of `rpl_data_i` as sampled when the command matched, and an end-of-frame bit of 0.
- R7: The first half-bit of the reply begins `GAP_BITS` bit periods after the end of the command frame, plus a latency of a few local clocks for synchronisation.
- R8: `bus_oe_o` is high for exactly the 20 half-bits of a reply and low at every other time.
- R9: A frame starts only on a rising edge of `bus_clk_i` while the node is idle. Further edges of the bus clock inside a frame, or during the node's own reply, do not restart decoding.
- R10: `cmd_valid_o` lasts exactly one local clock cycle per matched frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Local node clock |
| rst_i | input | 1 | Synchronous active-high reset |
| node_addr_i | input | 5 | This node's bus address |
| bus_clk_i | input | 1 | Bus clock line from the master |
| bus_dat_i | input | 1 | Level seen on the shared data line |
| bus_dat_o | output | 1 | Level the node drives on the data line |
| bus_oe_o | output | 1 | Enable of the node's data-line driver |
| cmd_o | output | 4 | Command field of the last matched frame |
| cmd_valid_o | output | 1 | One-cycle strobe for a matched command |
| rpl_data_i | input | 8 | Value returned in a read reply |

## Verification
A table of frames is driven one after another. The table covers matched read codes with different data bytes, and matched non-read codes at both ends of the read range and outside it. It also has addresses that differ from the node's in a low bit and in the top bit, a bad end-of-frame bit, and a bad start bit. Each case separates strobe-only behaviour from strobe-plus-reply and from full silence. For each reply the bench decodes every half-bit, measures the gap and counts the cycles with the driver enabled. The master toggles the bus clock on every bit, so a node that re-aligned on later edges would show up. Directed cases add a changed node address (address zero), frames sent back to back after a reply, and a reset that arrives in the middle of a reply.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    localparam int ADDR_W         = 5;
    localparam int CMD_W          = 4;
    localparam int DATA_W         = 8;
    localparam int CMD_CODES      = 1 << CMD_W;
    localparam int CMD_FRAME_BITS = 1 + ADDR_W + CMD_W + 1;
    localparam int RPL_FRAME_BITS = 1 + DATA_W + 1;

    localparam logic START_VAL = 1'b1;
    localparam logic EOF_VAL   = 1'b0;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CMD_W-1:0]  cmd_t;
    typedef logic [DATA_W-1:0] data_t;

    // Field order matches the arrival order on the wire (MSB first).
    typedef struct packed {
        logic  start;
        addr_t addr;
        cmd_t  cmd;
        logic  eof;
    } cmd_frame_t;

    typedef enum logic [0:0] {RX_IDLE, RX_RUN} rx_state_e;
    typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_SEND} tx_state_e;

    // Level of a Manchester-coded bit in its first or second half.
    function automatic logic mc_level(input logic bit_v, input logic second_half);
        return second_half ? ~bit_v : bit_v;
    endfunction

    function automatic logic framing_ok(input cmd_frame_t f);
        return (f.start == START_VAL) && (f.eof == EOF_VAL);
    endfunction

    function automatic logic [RPL_FRAME_BITS-1:0] build_reply(input data_t d);
        return {START_VAL, d, EOF_VAL};
    endfunction

endpackage

// File: rtl/sbus_sync.sv
module sbus_sync #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stage1 <= RST_VAL;
            q_o    <= RST_VAL;
        end else begin
            stage1 <= d_i;
            q_o    <= stage1;
        end
    end
endmodule

// File: rtl/sbus_rx.sv
module sbus_rx
    import sbus_pkg::*;
#(
    parameter int HALF_CYC = 8
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       listen_i,
    input  logic       line_clk_i,
    input  logic       line_dat_i,
    output logic       busy_o,
    output logic       done_o,
    output cmd_frame_t frame_o
);
    localparam int HALVES = 2 * CMD_FRAME_BITS;
    localparam int HCW    = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int HIW    = $clog2(HALVES);
    localparam logic [HCW-1:0] HC_LAST   = HCW'(HALF_CYC - 1);
    localparam logic [HCW-1:0] HC_SAMPLE = HCW'(HALF_CYC / 2);
    localparam logic [HIW-1:0] HI_LAST   = HIW'(HALVES - 1);

    rx_state_e                 state;
    logic [HCW-1:0]            hc;
    logic [HIW-1:0]            hi;
    logic [CMD_FRAME_BITS-1:0] sr;
    logic                      clk_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state  <= RX_IDLE;
            hc     <= '0;
            hi     <= '0;
            sr     <= '0;
            clk_q  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            clk_q  <= line_clk_i;
            done_o <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    if (listen_i && line_clk_i && !clk_q) begin
                        state <= RX_RUN;
                        hc    <= '0;
                        hi    <= '0;
                    end
                end
                RX_RUN: begin
                    // Only the first half of each bit carries its value.
                    if (hc == HC_SAMPLE && !hi[0])
                        sr <= {sr[CMD_FRAME_BITS-2:0], line_dat_i};
                    if (hc == HC_LAST) begin
                        hc <= '0;
                        if (hi == HI_LAST) begin
                            state  <= RX_IDLE;
                            done_o <= 1'b1;
                        end else begin
                            hi <= hi + HIW'(1);
                        end
                    end else begin
                        hc <= hc + HCW'(1);
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    assign busy_o  = (state == RX_RUN);
    assign frame_o = cmd_frame_t'(sr);
endmodule

// File: rtl/sbus_tx.sv
module sbus_tx
    import sbus_pkg::*;
#(
    parameter int HALF_CYC = 8,
    parameter int GAP_BITS = 2
) (
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  start_i,
    input  data_t data_i,
    output logic  busy_o,
    output logic  line_o,
    output logic  oe_o
);
    localparam int HALVES  = 2 * RPL_FRAME_BITS;
    localparam int GAP_CYC = GAP_BITS * 2 * HALF_CYC;
    localparam int GCW     = $clog2(GAP_CYC + 1);
    localparam int HCW     = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int HIW     = $clog2(HALVES);
    localparam logic [HCW-1:0] HC_LAST  = HCW'(HALF_CYC - 1);
    localparam logic [HIW-1:0] HI_LAST  = HIW'(HALVES - 1);
    localparam logic [GCW-1:0] GAP_LAST = GCW'(GAP_CYC - 1);

    tx_state_e                 state;
    logic [GCW-1:0]            wcnt;
    logic [HCW-1:0]            hc;
    logic [HIW-1:0]            hi;
    logic [RPL_FRAME_BITS-1:0] sr;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state <= TX_IDLE;
            wcnt  <= '0;
            hc    <= '0;
            hi    <= '0;
            sr    <= '0;
        end else begin
            unique case (state)
                TX_IDLE: begin
                    if (start_i) begin
                        state <= TX_WAIT;
                        wcnt  <= '0;
                        sr    <= build_reply(data_i);
                    end
                end
                TX_WAIT: begin
                    if (wcnt == GAP_LAST) begin
                        state <= TX_SEND;
                        hc    <= '0;
                        hi    <= '0;
                    end else begin
                        wcnt <= wcnt + GCW'(1);
                    end
                end
                TX_SEND: begin
                    if (hc == HC_LAST) begin
                        hc <= '0;
                        if (hi[0])
                            sr <= {sr[RPL_FRAME_BITS-2:0], 1'b0};
                        if (hi == HI_LAST)
                            state <= TX_IDLE;
                        else
                            hi <= hi + HIW'(1);
                    end else begin
                        hc <= hc + HCW'(1);
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    assign busy_o = (state != TX_IDLE);
    assign oe_o   = (state == TX_SEND);
    assign line_o = oe_o ? mc_level(sr[RPL_FRAME_BITS-1], hi[0]) : 1'b1;
endmodule

// File: rtl/sbus_node.sv
module sbus_node
    import sbus_pkg::*;
#(
    parameter int                   HALF_CYC  = 8,
    parameter int                   GAP_BITS  = 2,
    parameter logic [CMD_CODES-1:0] READ_MASK = 16'h00F0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] node_addr_i,
    input  logic              bus_clk_i,
    input  logic              bus_dat_i,
    output logic              bus_dat_o,
    output logic              bus_oe_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic              cmd_valid_o,
    input  logic [DATA_W-1:0] rpl_data_i
);
    logic       clk_s, dat_s;
    logic       rx_busy, rx_done;
    cmd_frame_t rx_frame;
    logic       tx_busy, tx_start;
    logic       hit;

    sbus_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   ({bus_clk_i, bus_dat_i}),
        .q_o   ({clk_s, dat_s})
    );

    sbus_rx #(.HALF_CYC(HALF_CYC)) u_rx (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .listen_i   (!tx_busy),
        .line_clk_i (clk_s),
        .line_dat_i (dat_s),
        .busy_o     (rx_busy),
        .done_o     (rx_done),
        .frame_o    (rx_frame)
    );

    assign hit      = rx_done && framing_ok(rx_frame) && (rx_frame.addr == node_addr_i);
    assign tx_start = hit && READ_MASK[rx_frame.cmd];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cmd_valid_o <= 1'b0;
            cmd_o       <= '0;
        end else begin
            cmd_valid_o <= hit;
            if (hit)
                cmd_o <= rx_frame.cmd;
        end
    end

    sbus_tx #(.HALF_CYC(HALF_CYC), .GAP_BITS(GAP_BITS)) u_tx (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (tx_start),
        .data_i  (rpl_data_i),
        .busy_o  (tx_busy),
        .line_o  (bus_dat_o),
        .oe_o    (bus_oe_o)
    );
endmodule

// File: rtl/sbus_node_chk.sv
module sbus_node_chk
    import sbus_pkg::*;
#(
    parameter logic [CMD_CODES-1:0] READ_MASK = 16'h00F0
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [ADDR_W-1:0] node_addr_i,
    input logic              rx_busy,
    input logic              rx_done,
    input cmd_frame_t        rx_frame,
    input logic              tx_busy,
    input logic              bus_oe_o,
    input logic              cmd_valid_o,
    input logic [CMD_W-1:0]  cmd_o
);
    // R1: outputs quiet on the first cycle out of reset
    a_r1_quiet_after_reset: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (!bus_oe_o && !cmd_valid_o));

    // R10: the strobe never lasts two cycles
    a_r10_single_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
        cmd_valid_o |=> !cmd_valid_o);

    // R3: a strobe follows a completed frame for this address
    a_r3_strobe_needs_match: assert property (@(posedge clk_i) disable iff (rst_i)
        (cmd_valid_o && !$past(rst_i)) |-> $past(rx_done && rx_frame.addr == node_addr_i));

    // R4: a bad end-of-frame bit never leads to a strobe
    a_r4_bad_eof_dropped: assert property (@(posedge clk_i) disable iff (rst_i)
        (rx_done && rx_frame.eof != EOF_VAL) |=> !cmd_valid_o);

    // R5: a reply only starts for a read code
    a_r5_reply_only_on_read: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(tx_busy) |-> (cmd_valid_o && READ_MASK[cmd_o]));

    // R8: the driver stays off while a frame is being received
    a_r8_no_drive_while_rx: assert property (@(posedge clk_i) disable iff (rst_i)
        rx_busy |-> !bus_oe_o);

    // R9: decoding never starts while the reply path is busy
    a_r9_no_rx_during_tx: assert property (@(posedge clk_i) disable iff (rst_i)
        (tx_busy && !rx_busy) |=> !rx_busy);
endmodule

bind sbus_node sbus_node_chk #(.READ_MASK(READ_MASK)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .node_addr_i (node_addr_i),
    .rx_busy     (rx_busy),
    .rx_done     (rx_done),
    .rx_frame    (rx_frame),
    .tx_busy     (tx_busy),
    .bus_oe_o    (bus_oe_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_o       (cmd_o)
);

// File: tb/sbus_node_tb.sv
module sbus_node_tb;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 8;
    localparam int GAP_BITS   = 2;
    localparam int GAP_CYC    = GAP_BITS * 2 * H;
    localparam int RPL_HALVES = 20;
    localparam logic [4:0] MY_ADDR = 5'h13;
    // {start, addr, cmd, eof, data, exp_valid, exp_reply}
    localparam int NV = 12;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 5'h13, 4'h4, 1'b0, 8'hA5, 1'b1, 1'b1},
        {1'b1, 5'h13, 4'h2, 1'b0, 8'h00, 1'b1, 1'b0},
        {1'b1, 5'h12, 4'h4, 1'b0, 8'h00, 1'b0, 1'b0},
        {1'b1, 5'h13, 4'h7, 1'b0, 8'h3C, 1'b1, 1'b1},
        {1'b1, 5'h13, 4'hF, 1'b0, 8'h00, 1'b1, 1'b0},
        {1'b1, 5'h13, 4'h5, 1'b1, 8'h00, 1'b0, 1'b0},
        {1'b0, 5'h13, 4'h4, 1'b0, 8'h00, 1'b0, 1'b0},
        {1'b1, 5'h03, 4'h6, 1'b0, 8'h00, 1'b0, 1'b0},
        {1'b1, 5'h13, 4'h0, 1'b0, 8'h00, 1'b1, 1'b0},
        {1'b1, 5'h13, 4'h6, 1'b0, 8'h81, 1'b1, 1'b1},
        {1'b1, 5'h13, 4'h3, 1'b0, 8'h00, 1'b1, 1'b0},
        {1'b1, 5'h13, 4'h8, 1'b0, 8'h00, 1'b1, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] node_addr = MY_ADDR;
    logic       m_clk = 1'b0;
    logic       m_dat = 1'b1;
    logic [7:0] rpl_data = 8'h00;
    logic       bus_dat_o, bus_oe_o, cmd_valid;
    logic [3:0] cmd;
    logic       line;

    int checks = 0;
    int fails  = 0;

    assign line = bus_oe_o ? bus_dat_o : m_dat;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbus_node #(.HALF_CYC(H), .GAP_BITS(GAP_BITS), .READ_MASK(16'h00F0)) u_dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .node_addr_i (node_addr),
        .bus_clk_i   (m_clk),
        .bus_dat_i   (line),
        .bus_dat_o   (bus_dat_o),
        .bus_oe_o    (bus_oe_o),
        .cmd_o       (cmd),
        .cmd_valid_o (cmd_valid),
        .rpl_data_i  (rpl_data)
    );

    // Monitors, sampled on the falling edge.
    int          cyc = 0;
    int          valid_tot = 0;
    int          oe_tot = 0;
    int          rise_cyc = 0;
    int          oe_pos = 0;
    logic        oe_q = 1'b0;
    logic [3:0]  last_cmd = '0;
    logic [19:0] halves = '0;

    always @(negedge clk) begin
        int pos;
        cyc <= cyc + 1;
        if (cmd_valid) begin
            valid_tot <= valid_tot + 1;
            last_cmd  <= cmd;
        end
        if (bus_oe_o) begin
            pos = oe_q ? oe_pos : 0;
            if (!oe_q) rise_cyc <= cyc;
            if (pos % H == H / 2) halves <= {halves[18:0], line};
            oe_pos <= pos + 1;
            oe_tot <= oe_tot + 1;
        end
        oe_q <= bus_oe_o;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half(input logic c, input logic d);
        m_clk = c;
        m_dat = d;
        repeat (H) @(negedge clk);
    endtask

    // R2: MSB first, logic 1 = high then low; bus clock rises each bit (R9)
    task automatic send_frame(input logic [10:0] f);
        for (int i = 10; i >= 0; i--) begin
            half(1'b1, f[i]);
            half(1'b0, ~f[i]);
        end
        m_clk = 1'b0;
        m_dat = 1'b1;
    endtask

    function automatic logic [19:0] mc_expect(input logic [7:0] d);
        logic [9:0]  b;
        logic [19:0] r;
        b = {1'b1, d, 1'b0};
        for (int i = 9; i >= 0; i--) r[2*i+1 -: 2] = {b[i], ~b[i]};
        return r;
    endfunction

    task automatic run_case(input logic [4:0] a, input logic [3:0] c, input logic s,
                            input logic e, input logic [7:0] d,
                            input logic exp_v, input logic exp_r);
        int v0, o0, end_cyc, dly;
        rpl_data = d;
        v0 = valid_tot;
        o0 = oe_tot;
        send_frame({s, a, c, e});
        end_cyc = cyc;
        repeat (GAP_CYC + RPL_HALVES * H + 24) @(negedge clk);
        // R3 / R4: strobe count
        chk((valid_tot - v0) == int'(exp_v), "R3/R4 strobe count", valid_tot - v0, int'(exp_v));
        if (exp_v) chk(last_cmd == c, "R3 cmd_o value", last_cmd, c);
        // R5 / R8: driver-on cycles
        chk((oe_tot - o0) == (exp_r ? RPL_HALVES * H : 0), "R5/R8 driver cycles",
            oe_tot - o0, exp_r ? RPL_HALVES * H : 0);
        if (exp_r) begin
            dly = rise_cyc - end_cyc;
            chk(dly >= GAP_CYC && dly <= GAP_CYC + 8, "R7 reply gap", dly, GAP_CYC);
            chk(halves == mc_expect(d), "R6 reply halves", halves, mc_expect(d));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(!bus_oe_o && !cmd_valid, "R1 in reset", {bus_oe_o, cmd_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!bus_oe_o && !cmd_valid, "R1 after reset", {bus_oe_o, cmd_valid}, 0);
        repeat (4) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_case(VEC[i][19:15], VEC[i][14:11], VEC[i][20], VEC[i][10],
                     VEC[i][9:2], VEC[i][1], VEC[i][0]);
        end

        // R3: a different node address, including zero
        node_addr = 5'h00;
        run_case(5'h00, 4'h5, 1'b1, 1'b0, 8'h5A, 1'b1, 1'b1);
        run_case(5'h13, 4'h5, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
        node_addr = MY_ADDR;

        // R9: frames right after a reply, no idle spacing
        run_case(5'h13, 4'h4, 1'b1, 1'b0, 8'hC3, 1'b1, 1'b1);
        run_case(5'h13, 4'h1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0);

        // R1: reset during a reply frees the line
        rpl_data = 8'hFF;
        send_frame({1'b1, 5'h13, 4'h6, 1'b0});
        repeat (GAP_CYC + 5 * H) @(negedge clk);
        chk(bus_oe_o, "R8 driving mid-reply", bus_oe_o, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!bus_oe_o, "R1 reset releases line", bus_oe_o, 0);
        repeat (RPL_HALVES * H) @(negedge clk);
        chk(!bus_oe_o && !cmd_valid, "R1 stays quiet", {bus_oe_o, cmd_valid}, 0);

        // R10: strobe still one cycle after the reset
        run_case(5'h13, 4'h9, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // R10: a strobe never spans two sampled cycles
    logic cv_q = 1'b0;
    always @(negedge clk) begin
        if (cmd_valid && cv_q) begin
            checks++;
            fails++;
            $display("FAIL R10 strobe width actual=%0d expected=%0d", 2, 1);
        end
        cv_q <= cmd_valid;
    end
endmodule